// File: doc/BRIEF.md
# Configuration Stream Preamble Locator

This block sits in the path of a configuration image that arrives one byte at a time over a valid/ready stream. It walks past the image's descriptive header (a fixed-size lead-in followed by text fields whose lengths are carried in the stream itself) and hunts for the synchronisation pattern that marks the start of the real configuration payload. Only the payload bytes leave on the output stream. Everything ahead of them is consumed silently.

Two search styles are selected by the `modeB` input, which must be held steady for a whole image. Style A skips the field list and then looks for a run of four 0xFF bytes. That run is part of the payload, so it is forwarded. Style B ignores the field list and scans from the first byte for 0xFF followed by a byte whose high nibble is 3. Both pattern bytes are dropped. When the pattern is found, the block reports the payload's byte position within the image. When the image ends first, it raises a failure flag and forwards nothing. Each image is delimited by `inLast`. The next image starts parsing from position zero.

Top module: `cfg_hdr_locator`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid`, `startValid` and `notFound` are 0.
- R2: In style A (`modeB`=0), the first field-length byte is at offset 15. Each following length byte sits `len`+3 bytes after the previous one. After four fields, the search window opens at the offset that a fifth length byte would have. 0xFF bytes before that window never count toward the pattern.
- R3: In style A, the first run of four consecutive 0xFF bytes inside the window is the pattern. The output stream is those four 0xFF bytes followed by every later input byte, unchanged and in order.
- R4: In style A, `dataStart` equals the offset of the first 0xFF of the matching run, counted from offset 0 at the image's first byte. `startValid` rises with it.
- R5: In style B (`modeB`=1), the search covers every byte from offset 0, including header bytes. The pattern is a byte 0xFF immediately followed by a byte whose bits [7:4] equal 4'h3. Neither byte is forwarded. `dataStart` is the offset of the 0x3X byte plus one.
- R6: A broken partial match restarts cleanly at the next byte. A run of 0xFF longer than the pattern (or split by other bytes) matches at its earliest valid position.
- R7: If `inLast` arrives without a match, `notFound` rises, `startValid` stays 0, and no output beat is produced.
- R8: A held output beat (`outValid`=1, `outReady`=0) keeps `outValid`, `outData` and `outLast` stable. While the four style-A pattern bytes are replayed, `inReady` is 0. After that, `inReady` follows `outReady`.
- R9: `outLast` is 1 on exactly the final forwarded byte, which is the image's last byte. When the style-A pattern completes on the last input byte, the fourth replayed 0xFF carries `outLast`.
- R10: `startValid`, `dataStart` and `notFound` hold after an image ends. They clear once the first byte of the next image is accepted, and that image is parsed from offset 0.
- R11: In style B, a pattern ending on the image's last byte sets `startValid` with `dataStart` equal to the image length, and produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeB | input | 1 | 0: four-0xFF pattern after field list; 1: 0xFF then 0x3X pattern from offset 0 |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Block accepts the input byte |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Input byte is the last of the image |
| outValid | output | 1 | Payload byte valid |
| outReady | input | 1 | Sink accepts the payload byte |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Payload byte is the last of the image |
| startValid | output | 1 | Pattern found in the current or most recent image |
| dataStart | output | OFFS_W | Payload start offset within the image |
| notFound | output | 1 | Most recent image ended without a pattern |

## Verification
The bench builds the block with its default parameters: a 15-byte lead-in, four fields with a three-byte step beyond each length value, a four-byte run and 20-bit offsets. These values let it place the search window at precise offsets inside images of a few hundred bytes. It can then pin 0xFF runs right up against the window edge and end images inside the header. Random images mix 0xFF-heavy filler with random back-pressure, so longer runs, overlapping partial matches and held replay beats all occur.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    ST_SCAN   = 2'd0,
    ST_REPLAY = 2'd1,
    ST_PASS   = 2'd2
  } scanState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic scanTake;  // a header/search byte is consumed this cycle
    logic restart;   // image finished: rewind the parse state
    logic foundA;    // four-byte run completed on the current byte
    logic foundB;    // two-byte pattern completed on the current byte
    logic giveUp;    // image ended without a pattern
    logic emitStep;  // one replayed pattern byte leaves
  } ctrlStrobe_t;

endpackage

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter int PREFIX_LEN  = 15,
  parameter int FIELD_COUNT = 4,
  parameter int FIELD_EXTRA = 3,
  parameter int A_RUN       = 4,
  parameter logic [3:0] B_NIBBLE = 4'h3,
  parameter int OFFS_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeB,
  input  logic [7:0]        inData,
  input  ctrlStrobe_t       strobe,
  output logic              aHit,
  output logic              bHit,
  output logic              emitLast,
  output logic              startValid,
  output logic [OFFS_W-1:0] dataStart,
  output logic              notFound
);

  localparam int FIDX_W = $clog2(FIELD_COUNT + 1);
  localparam int RUN_W  = (A_RUN > 2) ? $clog2(A_RUN) : 1;
  localparam logic [FIDX_W-1:0] FIELD_END = FIDX_W'(FIELD_COUNT);
  localparam logic [RUN_W-1:0]  RUN_TOP   = RUN_W'(A_RUN - 1);
  localparam logic [OFFS_W-1:0] RUN_BACK  = OFFS_W'(A_RUN - 1);
  localparam logic [OFFS_W-1:0] STEP_ADD  = OFFS_W'(FIELD_EXTRA);
  localparam logic [OFFS_W-1:0] FIRST_LEN = OFFS_W'(PREFIX_LEN);

  logic [OFFS_W-1:0] offsetQ;
  logic [OFFS_W-1:0] targetQ;
  logic [FIDX_W-1:0] fieldIdxQ;
  logic              windowQ;
  logic [RUN_W-1:0]  runQ;
  logic              prevFfQ;
  logic [RUN_W-1:0]  emitQ;

  logic isFf;
  logic atTarget;
  logic fieldsDone;
  logic windowOpen;
  logic patNibble;

  assign isFf       = (inData == 8'hFF);
  assign atTarget   = (offsetQ == targetQ);
  assign fieldsDone = (fieldIdxQ == FIELD_END);
  assign windowOpen = windowQ || (atTarget && fieldsDone);

  generate
    if (A_RUN > 1) begin : g_runCmp
      assign aHit = !modeB && windowOpen && isFf && (runQ == RUN_TOP);
    end else begin : g_runOne
      assign aHit = !modeB && windowOpen && isFf;
    end
  endgenerate

  assign patNibble = (inData[7:4] == B_NIBBLE);
  assign bHit      = modeB && prevFfQ && patNibble;
  assign emitLast  = (emitQ == RUN_TOP);

  // header walk, run counter and replay counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ   <= '0;
      targetQ   <= FIRST_LEN;
      fieldIdxQ <= '0;
      windowQ   <= 1'b0;
      runQ      <= '0;
      prevFfQ   <= 1'b0;
      emitQ     <= '0;
    end else if (strobe.restart) begin
      offsetQ   <= '0;
      targetQ   <= FIRST_LEN;
      fieldIdxQ <= '0;
      windowQ   <= 1'b0;
      runQ      <= '0;
      prevFfQ   <= 1'b0;
      emitQ     <= '0;
    end else begin
      if (strobe.scanTake) begin
        offsetQ <= offsetQ + 1'b1;
        if (atTarget && !fieldsDone) begin
          targetQ   <= offsetQ + OFFS_W'(inData) + STEP_ADD;
          fieldIdxQ <= fieldIdxQ + 1'b1;
        end
        if (atTarget && fieldsDone) begin
          windowQ <= 1'b1;
        end
        if (windowOpen && isFf) begin
          runQ <= runQ + 1'b1;
        end else begin
          runQ <= '0;
        end
        prevFfQ <= isFf;
      end
      if (strobe.emitStep) begin
        emitQ <= emitQ + 1'b1;
      end
    end
  end

  // result flags: cleared by the first byte of a new image, set on an outcome
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startValid <= 1'b0;
      dataStart  <= '0;
      notFound   <= 1'b0;
    end else begin
      if (strobe.scanTake && (offsetQ == '0)) begin
        startValid <= 1'b0;
        notFound   <= 1'b0;
        dataStart  <= '0;
      end
      if (strobe.giveUp) begin
        notFound <= 1'b1;
      end
      if (strobe.foundA) begin
        startValid <= 1'b1;
        dataStart  <= offsetQ - RUN_BACK;
      end
      if (strobe.foundB) begin
        startValid <= 1'b1;
        dataStart  <= offsetQ + 1'b1;
      end
    end
  end

  // the field walk never runs past the configured field count
  assert_field_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    fieldIdxQ <= FIELD_END);

  // no run is counted before the search window has opened
  assert_run_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    !windowQ |-> (runQ == '0));

  // success and failure are never reported together
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(startValid && notFound));

endmodule

// File: rtl/cfg_hdr_control.sv
module cfg_hdr_control
  import cfg_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        outReady,
  input  logic        aHit,
  input  logic        bHit,
  input  logic        emitLast,
  output ctrlStrobe_t strobe,
  output logic        inReady,
  output logic        outValid,
  output logic        outLast,
  output logic        replayOn
);

  scanState_t stateQ;
  scanState_t stateD;
  logic       lastQ;
  logic       lastD;

  always_comb begin
    stateD   = stateQ;
    lastD    = lastQ;
    strobe   = '0;
    inReady  = 1'b0;
    outValid = 1'b0;
    outLast  = 1'b0;
    replayOn = 1'b0;
    unique case (stateQ)
      ST_SCAN: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.scanTake = 1'b1;
          if (aHit) begin
            strobe.foundA = 1'b1;
            lastD         = inLast;
            stateD        = ST_REPLAY;
          end else if (bHit) begin
            strobe.foundB = 1'b1;
            if (inLast) begin
              strobe.restart = 1'b1;
            end else begin
              stateD = ST_PASS;
            end
          end else if (inLast) begin
            strobe.giveUp  = 1'b1;
            strobe.restart = 1'b1;
          end
        end
      end
      ST_REPLAY: begin
        replayOn = 1'b1;
        outValid = 1'b1;
        outLast  = emitLast && lastQ;
        if (outReady) begin
          strobe.emitStep = 1'b1;
          if (emitLast) begin
            strobe.restart = 1'b1;
            stateD         = lastQ ? ST_SCAN : ST_PASS;
          end
        end
      end
      ST_PASS: begin
        outValid = inValid;
        outLast  = inLast;
        inReady  = outReady;
        if (inValid && outReady && inLast) begin
          strobe.restart = 1'b1;
          stateD         = ST_SCAN;
        end
      end
      default: begin
        stateD = ST_SCAN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_SCAN;
      lastQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      lastQ  <= lastD;
    end
  end

  // a replay that started on the final byte ends the image, never passes on
  assert_replay_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REPLAY) && lastQ |=> (stateQ != ST_PASS));

endmodule

// File: rtl/cfg_hdr_locator.sv
module cfg_hdr_locator
  import cfg_hdr_pkg::*;
#(
  parameter int PREFIX_LEN  = 15,
  parameter int FIELD_COUNT = 4,
  parameter int FIELD_EXTRA = 3,
  parameter int A_RUN       = 4,
  parameter logic [3:0] B_NIBBLE = 4'h3,
  parameter int OFFS_W      = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeB,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outLast,
  output logic              startValid,
  output logic [OFFS_W-1:0] dataStart,
  output logic              notFound
);

  ctrlStrobe_t strobe;
  logic aHit;
  logic bHit;
  logic emitLast;
  logic replayOn;

  cfg_hdr_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .aHit     (aHit),
    .bHit     (bHit),
    .emitLast (emitLast),
    .strobe   (strobe),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .replayOn (replayOn)
  );

  cfg_hdr_datapath #(
    .PREFIX_LEN  (PREFIX_LEN),
    .FIELD_COUNT (FIELD_COUNT),
    .FIELD_EXTRA (FIELD_EXTRA),
    .A_RUN       (A_RUN),
    .B_NIBBLE    (B_NIBBLE),
    .OFFS_W      (OFFS_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .modeB      (modeB),
    .inData     (inData),
    .strobe     (strobe),
    .aHit       (aHit),
    .bHit       (bHit),
    .emitLast   (emitLast),
    .startValid (startValid),
    .dataStart  (dataStart),
    .notFound   (notFound)
  );

  assign outData = replayOn ? 8'hFF : inData;

  // a stalled beat stays put
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

  // nothing is forwarded before a pattern has been located
  assert_fwd_found_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> startValid);

  // a failed image stays silent
  assert_fail_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    notFound |-> !outValid);

endmodule

// File: tb/cfg_hdr_locator_tb_top.sv
module cfg_hdr_locator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OFFS_W     = 20;
  localparam int MAX_BYTES  = 1024;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeB = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [7:0]        inData = 8'h00;
  logic              inLast = 1'b0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [7:0]        outData;
  logic              outLast;
  logic              startValid;
  logic [OFFS_W-1:0] dataStart;
  logic              notFound;

  int checks = 0;
  int failures = 0;

  logic [7:0] streamBytes [MAX_BYTES];
  int         sLen = 0;
  logic [7:0] expBytes [MAX_BYTES];
  int         expCnt = 0;
  int         expStart = 0;
  bit         expFound = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_locator #(
    .PREFIX_LEN (15), .FIELD_COUNT (4), .FIELD_EXTRA (3),
    .A_RUN (4), .B_NIBBLE (4'h3), .OFFS_W (OFFS_W)
  ) dut_i (
    .clk (clk), .rstN (rstN), .modeB (modeB),
    .inValid (inValid), .inReady (inReady), .inData (inData), .inLast (inLast),
    .outValid (outValid), .outReady (outReady), .outData (outData), .outLast (outLast),
    .startValid (startValid), .dataStart (dataStart), .notFound (notFound)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // ---------- stream construction ----------
  task automatic push(input logic [7:0] b);
    streamBytes[sLen] = b;
    sLen++;
  endtask

  function automatic logic [7:0] fillByte(input bit allowFf);
    if (allowFf && ($urandom % 4 == 0)) return 8'hFF;
    return 8'($urandom % 255);
  endfunction

  task automatic pushFill(input int n, input bit allowFf);
    for (int i = 0; i < n; i++) push(fillByte(allowFf));
  endtask

  task automatic pushHeader(input int l0, input int l1, input int l2, input int l3,
                            input bit allowFf);
    int lens[4];
    lens[0] = l0; lens[1] = l1; lens[2] = l2; lens[3] = l3;
    pushFill(15, allowFf);
    for (int f = 0; f < 4; f++) begin
      push(8'(lens[f]));
      pushFill(lens[f] + 2, allowFf);
    end
  endtask

  // ---------- reference model from the requirements ----------
  task automatic refModel(input bit mB);
    int pos;
    expFound = 0; expCnt = 0; expStart = 0;
    if (!mB) begin
      pos = 15;
      for (int f = 0; f < 4; f++) begin
        if (pos >= sLen) begin pos = MAX_BYTES * 4; break; end
        pos = pos + int'(streamBytes[pos]) + 3;
      end
      for (int i = pos; i + 3 < sLen; i++) begin
        if (streamBytes[i] == 8'hFF && streamBytes[i+1] == 8'hFF &&
            streamBytes[i+2] == 8'hFF && streamBytes[i+3] == 8'hFF) begin
          expFound = 1; expStart = i; break;
        end
      end
    end else begin
      for (int i = 0; i + 1 < sLen; i++) begin
        if (streamBytes[i] == 8'hFF && streamBytes[i+1][7:4] == 4'h3) begin
          expFound = 1; expStart = i + 2; break;
        end
      end
    end
    if (expFound) begin
      for (int i = expStart; i < sLen; i++) begin
        expBytes[expCnt] = streamBytes[i];
        expCnt++;
      end
    end
  endtask

  // ---------- drive one image and check its outcome ----------
  task automatic runStream(input bit mB, input bit rndReady, input bit chkFirst,
                           input string tagFound, input string tagData);
    int idx = 0, outCnt = 0, cyc = 0, tail = 0, badIdx = -1, hsBad = 0;
    logic [7:0] gotB = 0, wantB = 0;
    bit pend = 0, stall = 0, firstDue = 0;
    logic [7:0] stallData = 0;
    logic stallLast = 0;
    refModel(mB);
    modeB = mB;
    while (tail < 12 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (firstDue) begin
        // R10: flags of the previous image cleared after the first new byte
        check(!notFound && !startValid, "R10", "flags after first byte",
              {notFound, startValid}, 0);
        firstDue = 0;
      end
      if (!pend) begin
        if (idx < sLen && ($urandom % 4 != 0)) begin
          inValid = 1; inData = streamBytes[idx]; inLast = (idx == sLen - 1); pend = 1;
        end else begin
          inValid = 0; inData = 8'h5A; inLast = 0;
        end
      end
      outReady = rndReady ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (stall && !(outValid && outData == stallData && outLast == stallLast)) hsBad++;
      stall = outValid && !outReady;
      stallData = outData;
      stallLast = outLast;
      if (outValid && outReady) begin
        if (!mB && outCnt < 4 && inReady) hsBad++;
        if (outCnt >= expCnt) begin
          if (badIdx < 0) begin badIdx = outCnt; gotB = outData; wantB = 8'h00; end
        end else if (outData != expBytes[outCnt] ||
                     outLast != (outCnt == expCnt - 1)) begin
          if (badIdx < 0) begin badIdx = outCnt; gotB = outData; wantB = expBytes[outCnt]; end
        end
        outCnt++;
      end
      if (inValid && inReady) begin
        idx++; pend = 0;
        if (idx == 1 && chkFirst && sLen > 1) firstDue = 1;
      end
      if (idx == sLen && !pend) tail++;
    end
    inValid = 0; inLast = 0;
    if (cyc >= 6000) check(0, "R8", "stream watchdog", cyc, 6000);
    check(startValid == expFound && notFound == !expFound, tagFound,
          "found/notFound", {startValid, notFound}, {expFound, !expFound});
    if (expFound)
      check(dataStart == OFFS_W'(expStart), tagFound, "dataStart", dataStart, expStart);
    check(outCnt == expCnt, tagData, "beat count", outCnt, expCnt);
    check(badIdx < 0, tagData, "payload/outLast byte", gotB, wantB);
    check(hsBad == 0, "R8", "handshake hold/replay", hsBad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check(0, "R1", "global watchdog", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: idle state after reset
    check(inReady == 1 && outValid == 0, "R1", "ready/valid after reset",
          {inReady, outValid}, 2'b10);
    check(startValid == 0 && notFound == 0, "R1", "flags after reset",
          {startValid, notFound}, 0);

    // R2/R3/R4: 0xFF-heavy header ignored, clean run after a gap
    sLen = 0; pushHeader(2, 0, 5, 1, 1); pushFill(3, 0);
    repeat (4) push(8'hFF); pushFill(10, 0);
    runStream(0, 0, 0, "R4", "R3");

    // R6: broken run then a five-long run
    sLen = 0; pushHeader(1, 1, 1, 1, 0);
    push(8'hFF); push(8'hFF); push(8'hFF); push(8'h00);
    repeat (5) push(8'hFF); push(8'h12); push(8'h34);
    runStream(0, 1, 1, "R6", "R6");

    // R2: run straddling the window edge must not count
    sLen = 0; pushHeader(0, 3, 2, 4, 0);
    sLen = sLen - 3; push(8'hFF); push(8'hFF); push(8'hFF);
    push(8'hFF); push(8'h00); pushFill(2, 0);
    repeat (4) push(8'hFF); pushFill(5, 0);
    runStream(0, 0, 1, "R2", "R2");

    // R9: pattern completes on the last byte
    sLen = 0; pushHeader(3, 2, 1, 0, 0); pushFill(4, 0);
    repeat (4) push(8'hFF);
    runStream(0, 1, 1, "R9", "R9");

    // R5: style B finds a pattern inside the header region
    sLen = 0; pushFill(3, 0); push(8'hFF); push(8'h31); pushFill(20, 0);
    runStream(1, 1, 1, "R5", "R5");

    // R6: style B overlap FF FF 3A
    sLen = 0; push(8'h00); push(8'hFF); push(8'hFF); push(8'h3A); pushFill(8, 1);
    runStream(1, 0, 1, "R6", "R6");

    // R11: style B pattern on the last byte
    sLen = 0; pushFill(9, 0); push(8'hFF); push(8'h3F);
    runStream(1, 1, 1, "R11", "R11");

    // R7: style A, no full run in the window
    sLen = 0; pushHeader(1, 2, 3, 4, 0);
    push(8'hFF); push(8'hFF); push(8'hFF); push(8'h01);
    push(8'hFF); push(8'hFF); push(8'hFF);
    runStream(0, 1, 1, "R7", "R7");

    // R7: style A image ends inside the header
    sLen = 0; repeat (12) push(8'hFF);
    runStream(0, 0, 1, "R7", "R7");

    // R7: style B with 0xFF never followed by 0x3X
    sLen = 0; push(8'hFF); push(8'h40); push(8'hFF); push(8'h2F); pushFill(6, 0);
    runStream(1, 1, 1, "R7", "R7");

    // random images
    for (int n = 0; n < 40; n++) begin
      bit mB;
      mB = 1'($urandom % 2);
      sLen = 0;
      pushHeader(int'($urandom % 9), int'($urandom % 9), int'($urandom % 9),
                 int'($urandom % 9), 1);
      pushFill(int'($urandom % 7), 1);
      if ($urandom % 10 != 0) begin
        if (!mB) repeat (4) push(8'hFF);
        else begin push(8'hFF); push(8'h30 | 8'($urandom % 16)); end
      end
      pushFill(int'($urandom % 21), 1);
      runStream(mB, 1'($urandom % 2), 1, mB ? "R5" : "R3", mB ? "R5" : "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule